// File: doc/BRIEF.md
# Instruction Cycle Timing Sequencer

This block is the timing and decode front end of a small accumulator machine's control unit. A 4-bit sequence counter, followed by a decoder, produces sixteen one-hot phase signals. The block uses these phases to pace the fetch and decode steps of every instruction. In the first three phases it issues the strobes that move the program counter into the address register, load the fetched memory word into the instruction register while bumping the program counter, and copy the instruction's address field into the address register. It also decodes the opcode into eight one-hot lines and latches the indirect bit.

In the fourth phase the block sorts the instruction into one of four classes: register-reference, input-output, indirect memory access, or direct memory access. The execute logic outside the block forms its own end-of-instruction conditions, such as the AND of a decoder line with a phase line. It feeds the result back as a synchronous clear request, which returns the sequence to phase 0 on the next edge. The memory and the datapath registers are not part of the block. They appear only as the fetched word input and the strobe outputs.

Top module: `tseq_top`

## Requirements
- R1: While the active-low asynchronous reset `rst_ni` is low, `t_o` is 16'h0001 (phase 0), and `d_o`, `ind_o`, `ir_o` and all class outputs are 0.
- R2: With no clear request, the phase advances by one on every clock, so `t_o` has exactly bit k set in phase k. After phase 15 it wraps to phase 0.
- R3: A high `sc_clr_i` at a clock edge puts the block in phase 0 after that edge, whatever the current phase. Clear wins over increment, and holding it high keeps the block in phase 0.
- R4: `ar_from_pc_o` is high only in phase 0. `ir_load_o` and `pc_inc_o` are high only in phase 1. `ar_from_ir_o` is high only in phase 2.
- R5: The instruction register captures `mem_word_i` at the edge that ends phase 1 and ignores it in every other phase. `ar_addr_o` always shows bits 11:0 of the instruction register.
- R6: At the edge that ends phase 2, `d_o` becomes the one-hot decode of instruction bits 14:12 (bit n set for opcode n) and `ind_o` takes instruction bit 15. Both hold their value at every other edge.
- R7: In phase 3 exactly one class output is high. It is `rr_o` when D7=1 and I=0, `io_o` when D7=1 and I=1, `indir_o` when D7=0 and I=1, and `direct_o` when D7=0 and I=0. In every other phase all four are low.
- R8: `rr_op_o` equals instruction bits 11:0 while `rr_o` is high, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sc_clr_i | input | 1 | Synchronous sequence clear request from execute logic |
| mem_word_i | input | 16 | Word read from memory at the address register |
| t_o | output | 16 | One-hot phase signals T0..T15 |
| d_o | output | 8 | One-hot opcode decode D0..D7 |
| ind_o | output | 1 | Latched indirect bit |
| ir_o | output | 16 | Instruction register contents |
| ar_from_pc_o | output | 1 | Load address register from program counter |
| ir_load_o | output | 1 | Load instruction register from memory |
| pc_inc_o | output | 1 | Increment program counter |
| ar_from_ir_o | output | 1 | Load address register from instruction bits 11:0 |
| ar_addr_o | output | 12 | Address field of the instruction register |
| rr_o | output | 1 | Register-reference class, phase 3 |
| io_o | output | 1 | Input-output class, phase 3 |
| indir_o | output | 1 | Indirect memory access class, phase 3 |
| direct_o | output | 1 | Direct memory access class, phase 3 |
| rr_op_o | output | 12 | Register-reference operation select field |

## Verification
The bench ends instructions with clears at several phases: early at phase 3, late at phase 4 and phase 5, and not at all, which forces a wrap from phase 15. A counter that lets increment win over clear, or that miscounts at the wrap, lands in the wrong phase for the next fetch. It drives the inverted word on the memory input outside phase 1, so an instruction register that loads in the wrong phase shows the wrong word. It also checks that the decode lines keep the previous instruction's value through phases 0 to 2, which catches a decoder left combinational off the register. Finally it holds the clear high in phase 0 and pulls reset in the middle of an instruction, which shows up a clear that only acts from certain phases and a reset that fails to clear the decode state.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 3;
  localparam int SC_W   = 4;

  typedef enum logic [1:0] {
    CLS_DIRECT   = 2'd0,
    CLS_INDIRECT = 2'd1,
    CLS_REGREF   = 2'd2,
    CLS_IO       = 2'd3
  } icls_e;
endpackage

// File: rtl/tseq_counter.sv
module tseq_counter #(
  parameter  int SC_W = 4,
  localparam int NT   = 1 << SC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  output logic [NT-1:0] t_o
);
  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sc_q <= '0;
    else if (clr_i) sc_q <= '0;
    else            sc_q <= sc_q + 1'b1;
  end

  for (genvar g = 0; g < NT; g++) begin : g_dec
    assign t_o[g] = (sc_q == SC_W'(g));
  end
endmodule

// File: rtl/tseq_ir.sv
module tseq_ir #(
  parameter  int WORD_W = 16,
  parameter  int OP_W   = 3,
  localparam int ADDR_W = WORD_W - OP_W - 1,
  localparam int ND     = 1 << OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic              dec_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] ir_o,
  output logic [ND-1:0]     d_o,
  output logic              ind_o
);
  logic [WORD_W-1:0] ir_q;
  logic [ND-1:0]     d_next, d_q;
  logic              i_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ir_q <= '0;
    else if (ld_i) ir_q <= word_i;
  end

  for (genvar g = 0; g < ND; g++) begin : g_op
    assign d_next[g] = (ir_q[ADDR_W +: OP_W] == OP_W'(g));
  end

  // decode is registered: lines are valid from the phase after dec_i
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      i_q <= 1'b0;
    end else if (dec_i) begin
      d_q <= d_next;
      i_q <= ir_q[WORD_W-1];
    end
  end

  assign ir_o  = ir_q;
  assign d_o   = d_q;
  assign ind_o = i_q;
endmodule

// File: rtl/tseq_class.sv
module tseq_class
  import tseq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              t3_i,
  input  logic              d7_i,
  input  logic              ind_i,
  input  logic [ADDR_W-1:0] field_i,
  output logic [3:0]        cls_o,
  output logic [ADDR_W-1:0] rr_op_o
);
  icls_e cls;

  always_comb begin
    if (d7_i) cls = ind_i ? CLS_IO : CLS_REGREF;
    else      cls = ind_i ? CLS_INDIRECT : CLS_DIRECT;
    cls_o = '0;
    if (t3_i) cls_o[cls] = 1'b1;
    rr_op_o = (t3_i && cls == CLS_REGREF) ? field_i : '0;
  end
endmodule

// File: rtl/tseq_top.sv
module tseq_top #(
  parameter  int WORD_W = tseq_pkg::WORD_W,
  parameter  int OP_W   = tseq_pkg::OP_W,
  parameter  int SC_W   = tseq_pkg::SC_W,
  localparam int ADDR_W = WORD_W - OP_W - 1,
  localparam int NT     = 1 << SC_W,
  localparam int ND     = 1 << OP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sc_clr_i,
  input  logic [WORD_W-1:0] mem_word_i,
  output logic [NT-1:0]     t_o,
  output logic [ND-1:0]     d_o,
  output logic              ind_o,
  output logic [WORD_W-1:0] ir_o,
  output logic              ar_from_pc_o,
  output logic              ir_load_o,
  output logic              pc_inc_o,
  output logic              ar_from_ir_o,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic              rr_o,
  output logic              io_o,
  output logic              indir_o,
  output logic              direct_o,
  output logic [ADDR_W-1:0] rr_op_o
);
  logic [NT-1:0]     t;
  logic [ND-1:0]     d;
  logic              ind;
  logic [WORD_W-1:0] ir;
  logic [3:0]        cls;

  tseq_counter #(.SC_W(SC_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (sc_clr_i),
    .t_o   (t)
  );

  tseq_ir #(.WORD_W(WORD_W), .OP_W(OP_W)) i_ir (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_i  (t[1]),
    .dec_i (t[2]),
    .word_i(mem_word_i),
    .ir_o  (ir),
    .d_o   (d),
    .ind_o (ind)
  );

  tseq_class #(.ADDR_W(ADDR_W)) i_cls (
    .t3_i   (t[3]),
    .d7_i   (d[ND-1]),
    .ind_i  (ind),
    .field_i(ir[ADDR_W-1:0]),
    .cls_o  (cls),
    .rr_op_o(rr_op_o)
  );

  assign t_o          = t;
  assign d_o          = d;
  assign ind_o        = ind;
  assign ir_o         = ir;
  assign ar_from_pc_o = t[0];
  assign ir_load_o    = t[1];
  assign pc_inc_o     = t[1];
  assign ar_from_ir_o = t[2];
  assign ar_addr_o    = ir[ADDR_W-1:0];
  assign direct_o     = cls[tseq_pkg::CLS_DIRECT];
  assign indir_o      = cls[tseq_pkg::CLS_INDIRECT];
  assign rr_o         = cls[tseq_pkg::CLS_REGREF];
  assign io_o         = cls[tseq_pkg::CLS_IO];
endmodule

// File: rtl/tseq_chk.sv
module tseq_chk #(
  parameter int WORD_W = 16,
  parameter int NT     = 16,
  parameter int ND     = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sc_clr_i,
  input logic [WORD_W-1:0] mem_word_i,
  input logic [NT-1:0]     t_o,
  input logic [ND-1:0]     d_o,
  input logic              ind_o,
  input logic [WORD_W-1:0] ir_o,
  input logic              ir_load_o,
  input logic              pc_inc_o,
  input logic              rr_o,
  input logic              io_o,
  input logic              indir_o,
  input logic              direct_o
);
  a_r2_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(t_o));

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sc_clr_i |=> t_o == {$past(t_o[NT-2:0]), $past(t_o[NT-1])});

  a_r3_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sc_clr_i |=> t_o[0]);

  a_r4_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ir_load_o || pc_inc_o) |-> t_o[1]);

  a_r5_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[1] |=> ir_o == $past(mem_word_i));

  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t_o[1] |=> $stable(ir_o));

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t_o[2] |=> $stable(d_o) && $stable(ind_o));

  a_r6_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(d_o));

  a_r7_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    t_o[3] |-> $countones({rr_o, io_o, indir_o, direct_o}) == 1);

  a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !t_o[3] |-> {rr_o, io_o, indir_o, direct_o} == 4'b0);
endmodule

bind tseq_top tseq_chk #(.WORD_W(WORD_W), .NT(NT), .ND(ND)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sc_clr_i  (sc_clr_i),
  .mem_word_i(mem_word_i),
  .t_o       (t_o),
  .d_o       (d_o),
  .ind_o     (ind_o),
  .ir_o      (ir_o),
  .ir_load_o (ir_load_o),
  .pc_inc_o  (pc_inc_o),
  .rr_o      (rr_o),
  .io_o      (io_o),
  .indir_o   (indir_o),
  .direct_o  (direct_o)
);

// File: tb/test_tseq_top.sv
`timescale 1ns/1ps
module test_tseq_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sc_clr_i = 1'b0;
  logic [15:0] mem_word_i = 16'h0;
  logic [15:0] t_o;
  logic [7:0]  d_o;
  logic        ind_o;
  logic [15:0] ir_o;
  logic        ar_from_pc_o, ir_load_o, pc_inc_o, ar_from_ir_o;
  logic [11:0] ar_addr_o;
  logic        rr_o, io_o, indir_o, direct_o;
  logic [11:0] rr_op_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  tseq_top i_tseq_top (
    .clk_i(clk_i), .rst_ni(rst_ni), .sc_clr_i(sc_clr_i), .mem_word_i(mem_word_i),
    .t_o(t_o), .d_o(d_o), .ind_o(ind_o), .ir_o(ir_o),
    .ar_from_pc_o(ar_from_pc_o), .ir_load_o(ir_load_o), .pc_inc_o(pc_inc_o),
    .ar_from_ir_o(ar_from_ir_o), .ar_addr_o(ar_addr_o),
    .rr_o(rr_o), .io_o(io_o), .indir_o(indir_o), .direct_o(direct_o),
    .rr_op_o(rr_op_o)
  );

  // class code: 0 direct, 1 indirect, 2 register-reference, 3 input-output
  // clr_at: phase in which the clear is raised, 0 = none (wrap after phase 15)
  typedef struct packed {
    logic [15:0] word;
    logic [3:0]  clr_at;
    logic [1:0]  cls;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{16'h7800, 4'd3, 2'd2},
    '{16'hF400, 4'd3, 2'd3},
    '{16'h8123, 4'd5, 2'd1},
    '{16'h3456, 4'd4, 2'd0},
    '{16'h5FFF, 4'd0, 2'd0},
    '{16'h7001, 4'd3, 2'd2},
    '{16'hA0AA, 4'd9, 2'd1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_reset_state();
    chk(t_o == 16'h0001, "R1 t_o", 32'(t_o), 32'h1);
    chk(d_o == 8'h00, "R1 d_o", 32'(d_o), 32'h0);
    chk(ind_o == 1'b0, "R1 ind_o", 32'(ind_o), 32'h0);
    chk(ir_o == 16'h0, "R1 ir_o", 32'(ir_o), 32'h0);
    chk({io_o, rr_o, indir_o, direct_o} == 4'b0, "R1 class",
        32'({io_o, rr_o, indir_o, direct_o}), 32'h0);
  endtask

  initial begin
    logic [7:0] prev_d;
    logic       prev_i;
    #1;
    chk_reset_state();
    prev_d = 8'h00;
    prev_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int v = 0; v < NV; v++) begin
      logic [15:0] w;
      logic [7:0]  ed;
      logic [3:0]  ecls;
      bit          cleared;
      w = VECS[v].word;
      ed = 8'(1) << w[14:12];
      ecls = 4'(1) << VECS[v].cls;
      cleared = 0;
      for (int k = 0; k < 16; k++) begin
        chk(t_o == 16'(32'(1) << k), "R2 phase", 32'(t_o), 32'(1) << k);
        chk(ar_from_pc_o == (k == 0) && ir_load_o == (k == 1) && pc_inc_o == (k == 1)
            && ar_from_ir_o == (k == 2), "R4 strobes",
            32'({ar_from_pc_o, ir_load_o, pc_inc_o, ar_from_ir_o}),
            32'({k == 0, k == 1, k == 1, k == 2}));
        if (k >= 2) begin
          chk(ir_o == w, "R5 ir", 32'(ir_o), 32'(w));
          chk(ar_addr_o == w[11:0], "R5 addr", 32'(ar_addr_o), 32'(w[11:0]));
        end
        if (k >= 3) begin
          chk(d_o == ed && ind_o == w[15], "R6 decode", 32'({ind_o, d_o}), 32'({w[15], ed}));
        end else begin
          chk(d_o == prev_d && ind_o == prev_i, "R6 hold", 32'({ind_o, d_o}),
              32'({prev_i, prev_d}));
        end
        chk({io_o, rr_o, indir_o, direct_o} == ((k == 3) ? ecls : 4'b0), "R7 class",
            32'({io_o, rr_o, indir_o, direct_o}), 32'((k == 3) ? ecls : 4'b0));
        chk(rr_op_o == ((k == 3 && VECS[v].cls == 2'd2) ? w[11:0] : 12'h0), "R8 op",
            32'(rr_op_o), 32'((k == 3 && VECS[v].cls == 2'd2) ? w[11:0] : 12'h0));
        mem_word_i = (k == 1) ? w : ~w;
        sc_clr_i = (VECS[v].clr_at != 0) && (k == int'(VECS[v].clr_at));
        cleared = sc_clr_i;
        @(negedge clk_i);
        sc_clr_i = 1'b0;
        if (cleared) break;
      end
      if (cleared) chk(t_o == 16'h0001, "R3 clear", 32'(t_o), 32'h1);
      else         chk(t_o == 16'h0001, "R2 wrap", 32'(t_o), 32'h1);
      prev_d = ed;
      prev_i = w[15];
    end

    // clear held in phase 0 keeps the sequence there
    sc_clr_i = 1'b1;
    for (int n = 0; n < 2; n++) begin
      @(negedge clk_i);
      chk(t_o == 16'h0001 && ar_from_pc_o, "R3 hold at T0", 32'(t_o), 32'h1);
    end
    sc_clr_i = 1'b0;

    // reset in the middle of an instruction
    for (int k = 0; k < 5; k++) begin
      mem_word_i = (k == 1) ? 16'hC3A5 : 16'h0F0F;
      @(negedge clk_i);
    end
    chk(t_o == 16'h0020, "R2 before reset", 32'(t_o), 32'h20);
    rst_ni = 1'b0;
    #1;
    chk_reset_state();
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(t_o == 16'h0002, "R2 after reset", 32'(t_o), 32'h2);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule